// File: doc/BRIEF.md
# Variable-Length Instruction Stream Framer

The framer sits between an instruction fetch path and a decoder. It takes 32-bit words one at a time over a valid/ready handshake and groups them into instructions that are one or two words long. For each instruction it presents one output beat with these fields: the byte address of the first word, both words, a format class, a length flag and an invalid flag. The decoder accepts the beat with its own ready signal.

The length is settled from the first word alone. The framer checks the top nibble, the full 8-bit opcode and a 4-bit addressing-mode field at bits 13:10. A second word is requested only when that check calls for one, so the framer never consumes a word that belongs to the next instruction. Words that fit no format are passed through as one-word data items with the invalid flag set.

A synchronous flush realigns the framer to a new start address. It drops a half-framed instruction and any beat the decoder has not taken. After each emitted instruction the address moves on by 4 or 8 bytes.

Top module: `ifr_framer`

## Requirements
- R1: `out_fmt` is derived from bits 31:28 of the first word. Nibbles 0x0 and 0x1 give 0 (control). Nibbles 0x2 and 0x3 give 1 (compare-and-branch). Nibbles 0x5 to 0x7 give 2 (register). Nibbles 0x8 to 0xC give 3 (memory). Every other nibble gives 4 (data).
- R2: Classes 0, 1 and 2 are always one word (`out_two`=0) with `out_invalid`=0. Every one-word beat carries `out_word2`=0.
- R3: A class-3 word is two words long (`out_two`=1) when both of these hold: its opcode in bits 31:24 is one of 0x80, 0x82, 0x84, 0x85, 0x86, 0x88, 0x8A, 0x8C, 0x90, 0x92, 0x98, 0x9A, 0xA0, 0xA2, 0xAC, 0xB0, 0xB2, 0xC0, 0xC2, 0xC8 or 0xCA; and its mode field in bits 13:10 is 5 or at least 12. The second input word then appears on `out_word2`.
- R4: A class-3 word with an opcode outside the R3 list, or with mode 6, is emitted as one word with `out_invalid`=1. Any other mode with a listed opcode is one word and valid.
- R5: A word of class 4 is emitted as a one-word item with `out_invalid`=1 and `out_word1` equal to the word.
- R6: After a one-word instruction, the next accepted input word begins a new instruction.
- R7: While `out_valid`=1 and `out_ready`=0, all output fields hold steady and `in_ready`=0. No input word is consumed until the beat is taken.
- R8: `out_addr` of each instruction equals the previous instruction's address plus 4 (one word) or plus 8 (two words).
- R9: Flush takes priority over all other activity. In the flush cycle `in_ready`=0. A held first word and any pending beat are dropped, so `out_valid`=0 in the next cycle. The next instruction is placed at `flush_addr`.
- R10: After reset, `out_valid`=0, `in_ready`=1 and the start address is `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop framing state and load a new start address |
| flush_addr | input | ADDR_W | Start address loaded on flush |
| in_valid | input | 1 | Input word present |
| in_data | input | WORD_W | Input word, little-endian |
| in_ready | output | 1 | Framer takes the word this cycle |
| out_valid | output | 1 | Instruction beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_addr | output | ADDR_W | Byte address of the first word |
| out_word1 | output | WORD_W | First word |
| out_word2 | output | WORD_W | Second word, zero for one-word items |
| out_fmt | output | 3 | Format class code (R1) |
| out_two | output | 1 | 1 for a two-word instruction |
| out_invalid | output | 1 | Word fits no valid format |

## Verification
The bench drives two functions into the same cycle: a flush and a pending input word. It raises `flush` while `in_valid` is high, with a first word already held waiting for its second word. It then checks three things: `in_ready` is low in that cycle, the held word is gone, and the pending word comes out as a fresh one-word instruction at the flush address. It also raises a flush while an emitted beat is stalled by backpressure, and checks that the beat vanishes and that addressing restarts from the new base.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

   typedef enum logic [2:0] {
      FMT_CTRL = 3'd0,
      FMT_COBR = 3'd1,
      FMT_REG  = 3'd2,
      FMT_MEM  = 3'd3,
      FMT_DATA = 3'd4
   } fmt_t;

   // Memory-class opcodes that exist; anything else in 0x80..0xCF is undefined.
   function automatic logic mem_op_defined(input logic [7:0] op);
      logic hit;
      case (op)
         8'h80, 8'h82, 8'h84, 8'h85, 8'h86, 8'h88, 8'h8A, 8'h8C,
         8'h90, 8'h92, 8'h98, 8'h9A,
         8'hA0, 8'hA2, 8'hAC,
         8'hB0, 8'hB2,
         8'hC0, 8'hC2, 8'hC8, 8'hCA: hit = 1'b1;
         default:                    hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/ifr_classify.sv
module ifr_classify
   import ifr_pkg::*;
#(
   parameter int          WORD_W     = 32,
   parameter int          MODE_LSB   = 10,
   parameter int          MODE_W     = 4,
   parameter logic [15:0] LONG_MODES = 16'hF020,
   parameter logic [15:0] BAD_MODES  = 16'h0040
) (
   input  logic [WORD_W-1:0] word,
   output fmt_t              fmt,
   output logic              two_word,
   output logic              bad
);

   localparam int NIB_MSB = WORD_W - 1;
   localparam int OP_W    = 8;
   localparam int N_MODES = 1 << MODE_W;

   if (WORD_W != 32) begin : g_chk_word
      $error("ifr_classify: field positions assume a 32-bit word");
   end
   if (N_MODES != 16) begin : g_chk_mode
      $error("ifr_classify: mode masks are 16 bits wide");
   end
   if ((LONG_MODES & BAD_MODES) != 16'h0) begin : g_chk_masks
      $error("ifr_classify: a mode cannot be both long and invalid");
   end

   logic [3:0]        nib;
   logic [OP_W-1:0]   op;
   logic [MODE_W-1:0] mode;
   logic              op_ok;

   assign nib   = word[NIB_MSB -: 4];
   assign op    = word[NIB_MSB -: OP_W];
   assign mode  = word[MODE_LSB +: MODE_W];
   assign op_ok = mem_op_defined(op);

   always_comb begin
      case (nib)
         4'h0, 4'h1:             fmt = FMT_CTRL;
         4'h2, 4'h3:             fmt = FMT_COBR;
         4'h5, 4'h6, 4'h7:       fmt = FMT_REG;
         4'h8, 4'h9, 4'hA,
         4'hB, 4'hC:             fmt = FMT_MEM;
         default:                fmt = FMT_DATA;
      endcase
   end

   always_comb begin
      two_word = 1'b0;
      bad      = 1'b0;
      if (fmt == FMT_DATA) begin
         bad = 1'b1;
      end else if (fmt == FMT_MEM) begin
         two_word = op_ok && LONG_MODES[mode];
         bad      = !op_ok || BAD_MODES[mode];
      end
   end

endmodule

// File: rtl/ifr_addr.sv
module ifr_addr #(
   parameter int                 ADDR_W     = 32,
   parameter int                 WORD_W     = 32,
   parameter logic [ADDR_W-1:0]  RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              step_two,
   output logic [ADDR_W-1:0] addr_q
);

   localparam int                WORD_BYTES = WORD_W / 8;
   localparam logic [ADDR_W-1:0] INC_ONE    = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] INC_TWO    = ADDR_W'(2 * WORD_BYTES);

   if (ADDR_W < 4) begin : g_chk_addr
      $error("ifr_addr: address too narrow for the step sizes");
   end
   if ((WORD_W % 8) != 0) begin : g_chk_bytes
      $error("ifr_addr: word width must be whole bytes");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= RESET_ADDR;
      else if (load)
         addr_q <= load_val;
      else if (step)
         addr_q <= addr_q + (step_two ? INC_TWO : INC_ONE);
   end

   AST_FLUSH_LOADS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(load_val)); // R9
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> addr_q == $past(addr_q) + ($past(step_two) ? INC_TWO : INC_ONE)); // R8

endmodule

// File: rtl/ifr_ctrl.sv
module ifr_ctrl
   import ifr_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  fmt_t              cls_fmt,
   input  logic              cls_two,
   input  logic              cls_bad,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] word1_q,
   output logic [WORD_W-1:0] word2_q,
   output fmt_t              fmt_q,
   output logic              two_q,
   output logic              bad_q,
   output logic              emit
);

   typedef enum logic [1:0] {
      ST_HEAD = 2'd0,
      ST_TAIL = 2'd1,
      ST_HOLD = 2'd2
   } st_t;

   st_t st_q;

   assign in_ready  = !flush && (st_q == ST_HEAD || st_q == ST_TAIL);
   assign out_valid = (st_q == ST_HOLD);
   assign emit      = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_HEAD;
         word1_q <= '0;
         word2_q <= '0;
         fmt_q   <= FMT_CTRL;
         two_q   <= 1'b0;
         bad_q   <= 1'b0;
      end else if (flush) begin
         st_q <= ST_HEAD;
      end else begin
         case (st_q)
            ST_HEAD: if (in_valid) begin
               word1_q <= in_data;
               word2_q <= '0;
               fmt_q   <= cls_fmt;
               two_q   <= cls_two;
               bad_q   <= cls_bad;
               st_q    <= cls_two ? ST_TAIL : ST_HOLD;
            end
            ST_TAIL: if (in_valid) begin
               word2_q <= in_data;
               st_q    <= ST_HOLD;
            end
            ST_HOLD: if (out_ready) begin
               st_q <= ST_HEAD;
            end
            default: st_q <= ST_HEAD;
         endcase
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> out_valid && $stable(word1_q)
         && $stable(word2_q) && $stable(fmt_q) && $stable(two_q) && $stable(bad_q)); // R7
   AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid); // R9
   AST_ONE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !two_q) |-> word2_q == '0); // R2
   AST_LONG_IS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && two_q) |-> (fmt_q == FMT_MEM && !bad_q)); // R3
   AST_DATA_IS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fmt_q == FMT_DATA) |-> (bad_q && !two_q)); // R5

endmodule

// File: rtl/ifr_framer.sv
module ifr_framer
   import ifr_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                WORD_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   parameter logic [15:0]       LONG_MODES = 16'hF020,
   parameter logic [15:0]       BAD_MODES  = 16'h0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [WORD_W-1:0] out_word1,
   output logic [WORD_W-1:0] out_word2,
   output logic [2:0]        out_fmt,
   output logic              out_two,
   output logic              out_invalid
);

   fmt_t cls_fmt;
   logic cls_two;
   logic cls_bad;
   fmt_t fmt_q;
   logic emit;

   ifr_classify #(
      .WORD_W     (WORD_W),
      .LONG_MODES (LONG_MODES),
      .BAD_MODES  (BAD_MODES)
   ) u_cls (
      .word     (in_data),
      .fmt      (cls_fmt),
      .two_word (cls_two),
      .bad      (cls_bad)
   );

   ifr_ctrl #(
      .WORD_W (WORD_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .cls_fmt   (cls_fmt),
      .cls_two   (cls_two),
      .cls_bad   (cls_bad),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .word1_q   (out_word1),
      .word2_q   (out_word2),
      .fmt_q     (fmt_q),
      .two_q     (out_two),
      .bad_q     (out_invalid),
      .emit      (emit)
   );

   ifr_addr #(
      .ADDR_W     (ADDR_W),
      .WORD_W     (WORD_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (flush),
      .load_val (flush_addr),
      .step     (emit),
      .step_two (out_two),
      .addr_q   (out_addr)
   );

   assign out_fmt = fmt_q;

   AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> $stable(out_addr)); // R7

endmodule

// File: tb/tb_ifr_framer.sv
module tb_ifr_framer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [31:0] flush_addr = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_addr;
   logic [31:0] out_word1;
   logic [31:0] out_word2;
   logic [2:0]  out_fmt;
   logic        out_two;
   logic        out_invalid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ifr_framer dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_word1(out_word1), .out_word2(out_word2), .out_fmt(out_fmt),
      .out_two(out_two), .out_invalid(out_invalid)
   );

   // {word1, word2, class, two, invalid}
   localparam int NV = 14;
   localparam logic [68:0] VEC [NV] = '{
      {32'h08000000, 32'h0,        3'd0, 1'b0, 1'b0},
      {32'h3A000000, 32'h0,        3'd1, 1'b0, 1'b0},
      {32'h59000000, 32'h0,        3'd2, 1'b0, 1'b0},
      {32'h90001400, 32'hDEAD0001, 3'd3, 1'b1, 1'b0},
      {32'h8C003000, 32'h12345678, 3'd3, 1'b1, 1'b0},
      {32'hB2003C00, 32'hCAFEF00D, 3'd3, 1'b1, 1'b0},
      {32'h80000800, 32'h0,        3'd3, 1'b0, 1'b0},
      {32'h90001800, 32'h0,        3'd3, 1'b0, 1'b1},
      {32'h81003000, 32'h0,        3'd3, 1'b0, 1'b1},
      {32'h40000000, 32'h0,        3'd4, 1'b0, 1'b1},
      {32'hF0000000, 32'h0,        3'd4, 1'b0, 1'b1},
      {32'hCA002C00, 32'h0,        3'd3, 1'b0, 1'b0},
      {32'h1F000000, 32'h0,        3'd0, 1'b0, 1'b0},
      {32'h7F000000, 32'h0,        3'd2, 1'b0, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_word(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic wait_out();
      int n = 0;
      @(negedge clk);
      while (!out_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic take();
      out_ready = 1'b1;
      @(posedge clk);
      #1 out_ready = 1'b0;
   endtask

   task automatic do_flush(input logic [31:0] a);
      @(negedge clk);
      flush = 1'b1;
      flush_addr = a;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_addr;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 0);
      chk(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 1);

      // first instruction after reset lands at RESET_ADDR (0)
      send_word(32'h08000000);
      wait_out();
      chk(out_addr == 32'h0, "R10 start address", 64'(out_addr), 0);
      take();

      do_flush(32'h100);
      exp_addr = 32'h100;

      for (int i = 0; i < NV; i++) begin
         logic [31:0] w1, w2;
         logic [2:0] c;
         logic t, b;
         {w1, w2, c, t, b} = VEC[i];
         send_word(w1);
         if (t) send_word(w2);
         wait_out();
         chk(out_valid, "R1 beat present", 64'(out_valid), 1);
         chk(out_fmt == c, "R1 class", 64'(out_fmt), 64'(c));
         chk(out_word1 == w1, "R6 word1 framing", 64'(out_word1), 64'(w1));
         chk(out_two == t, (c == 3'd3) ? "R3 length" : "R2 length", 64'(out_two), 64'(t));
         chk(out_word2 == w2, t ? "R3 word2" : "R2 word2 zero", 64'(out_word2), 64'(w2));
         chk(out_invalid == b, (c == 3'd4) ? "R5 invalid" : "R4 invalid", 64'(out_invalid), 64'(b));
         chk(out_addr == exp_addr, "R8 address", 64'(out_addr), 64'(exp_addr));
         take();
         exp_addr = exp_addr + (t ? 32'd8 : 32'd4);
      end

      // R6: undefined opcode with a long mode must not swallow the next word
      send_word(32'h81003400);
      wait_out();
      chk(out_two == 1'b0, "R4 undefined op one word", 64'(out_two), 0);
      take();
      send_word(32'h12000000);
      wait_out();
      chk(out_word1 == 32'h12000000, "R6 next word starts instruction", 64'(out_word1), 64'h12000000);
      chk(out_addr == exp_addr + 32'd4, "R8 address after one-word", 64'(out_addr), 64'(exp_addr + 32'd4));
      take();
      exp_addr = exp_addr + 32'd8;

      // R7: backpressure with a two-word beat and a waiting input word
      send_word(32'h98003400);
      send_word(32'hA5A5A5A5);
      wait_out();
      in_valid = 1'b1;
      in_data  = 32'h59000000;
      for (int k = 0; k < 5; k++) begin
         #1;
         chk(in_ready == 1'b0, "R7 in_ready low while held", 64'(in_ready), 0);
         chk(out_valid && out_word2 == 32'hA5A5A5A5 && out_addr == exp_addr,
             "R7 beat stable", 64'(out_word2), 64'hA5A5A5A5);
         @(negedge clk);
      end
      take();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
      wait_out();
      chk(out_word1 == 32'h59000000, "R7 held word taken after beat", 64'(out_word1), 64'h59000000);
      chk(out_addr == exp_addr + 32'd8, "R8 address after two-word", 64'(out_addr), 64'(exp_addr + 32'd8));
      take();

      // R9: flush and pending input word in the same cycle, first word held
      send_word(32'h90001400);
      @(negedge clk);
      flush = 1'b1;
      flush_addr = 32'h2000;
      in_valid = 1'b1;
      in_data = 32'h3A000000;
      #1;
      chk(in_ready == 1'b0, "R9 in_ready low during flush", 64'(in_ready), 0);
      @(posedge clk);
      #1 flush = 1'b0;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
      wait_out();
      chk(out_word1 == 32'h3A000000 && out_two == 1'b0 && out_fmt == 3'd1,
          "R9 held word dropped", 64'(out_word1), 64'h3A000000);
      chk(out_addr == 32'h2000, "R9 new base", 64'(out_addr), 64'h2000);
      take();

      // R9: flush while a beat is stalled
      send_word(32'h08000000);
      wait_out();
      do_flush(32'h3000);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 pending beat dropped", 64'(out_valid), 0);
      send_word(32'h59000000);
      wait_out();
      chk(out_addr == 32'h3000 && out_word1 == 32'h59000000, "R9 restart address",
          64'(out_addr), 64'h3000);
      take();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule